// File: doc/BRIEF.md
# Asynchronous Handshake Bus Register Slave

This block is the target side of a bus with no shared clock. The master places an 18-bit byte address, a 2-bit transfer code and, for writes, 16 bits of data on the bus. It then raises a master strobe. The slave performs the transfer, raises its answer strobe, and holds it until the master withdraws its strobe. Each edge waits for the edge that came before it, so slaves of any speed can share the bus. All timing margin belongs to the master. The slave only follows the interlock.

Inside, the block runs on its own clock. The strobe and the bus fields each pass through a two-flop synchroniser. The fields are latched once the strobe has been seen, and they are decoded against a small window of word registers. That window sits in the device page, which is the top 8 KB of the address space. Reads, word writes and single-byte writes are supported. There is also a paused read. It opens a read-modify-write on one register, and the next write to that register closes it.

The bus edge is a strobe interlock, not a valid/ready stream. The master's strobe acts as "valid" and the slave's answer strobe acts as "ready/done". No back-pressure exists beyond holding back the answer. A transfer the slave refuses is simply never answered, and the master is expected to time out.

Top module: `async_bus_slave`

## Requirements
- R1: After reset, every register reads 0x0000, `bus_ssync` is low and `bus_dout` is zero.
- R2: The slave answers only when address bits [17:13] are all ones and the low 13 bits lie in [WIN_BASE, WIN_BASE + 2*NUM_REGS). With the defaults, that is byte addresses 0x3FF00 to 0x3FF0F. The register index is (offset - WIN_BASE) >> 1. A transfer to any other address never raises `bus_ssync`.
- R3: The transfer code `bus_ctl` means: 2'b00 read, 2'b01 paused read, 2'b10 word write, 2'b11 byte write.
- R4: For a read or a paused read, `bus_dout` carries the addressed register while `bus_ssync` is high. It is all zeros whenever `bus_ssync` is low, and throughout any write.
- R5: A word write replaces all 16 bits of the addressed register with `bus_din`.
- R6: A byte write with address bit 0 = 0 updates bits [7:0] from `bus_din[7:0]`. With address bit 0 = 1, it updates bits [15:8] from `bus_din[15:8]`. The other byte keeps its value.
- R7: `bus_ssync` rises only while `bus_msync` is high, within 8 clocks of `bus_msync` rising. It stays high while `bus_msync` stays high. It falls within 8 clocks after `bus_msync` falls.
- R8: An answered paused read locks its register. An answered word or byte write to the locked register performs the write and releases the lock.
- R9: While a lock is held, a write or paused read to a different register is refused: there is no `bus_ssync` and no register changes. Plain reads to any mapped register are still answered.
- R10: After a refused or unmapped transfer, the slave returns to idle once `bus_msync` falls. The next transfer is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 18 | Byte address from the master |
| bus_ctl | input | 2 | Transfer code |
| bus_din | input | 16 | Write data from the master |
| bus_msync | input | 1 | Master strobe |
| bus_dout | output | 16 | Read data to the master, zero when not answering |
| bus_ssync | output | 1 | Slave answer strobe |

## Verification
The in-RTL assertions watch, on every clock, several handshake properties. The answer may only rise while the synchronised master strobe is high, and it must be held while that strobe stays high. Read data stays at zero outside an answer. An unmapped or lock-refused transfer is never answered, and a write to the locked register releases the lock. Only the bench's scenarios can show the full behaviour. That covers register contents after word writes and after each byte lane, the exact edges of the address window, and the full paused-read, refused-write, completing-write sequence followed by recovery.

// File: rtl/abs_pkg.sv
package abs_pkg;
  typedef enum logic [1:0] {
    XF_READ       = 2'b00,
    XF_READ_PAUSE = 2'b01,
    XF_WR_WORD    = 2'b10,
    XF_WR_BYTE    = 2'b11
  } xfer_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_HOLD,
    ST_REFUSE
  } slv_state_e;
endpackage

// File: rtl/abs_sync.sv
module abs_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/abs_decode.sv
module abs_decode #(
  parameter int ADDR_W   = 18,
  parameter int IO_W     = 13,
  parameter int WIN_BASE = 'h1F00,
  parameter int NUM_REGS = 8,
  parameter int LANE_W   = 1,
  parameter int IDX_W    = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam int NB = 1 << LANE_W;
  localparam logic [IO_W:0] LO = (IO_W+1)'(WIN_BASE);
  localparam logic [IO_W:0] HI = (IO_W+1)'(WIN_BASE + NUM_REGS * NB);

  logic          in_page;
  logic [IO_W:0] off;
  logic [IO_W:0] rel;

  always_comb begin
    in_page = &addr[ADDR_W-1:IO_W];
    off     = {1'b0, addr[IO_W-1:0]};
    rel     = off - LO;
    hit     = in_page && (off >= LO) && (off < HI);
    idx     = IDX_W'(rel >> LANE_W);
  end
endmodule

// File: rtl/abs_regfile.sv
module abs_regfile #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rdata
);
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] mem [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    for (genvar l = 0; l < NB; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mem[i][l*8 +: 8] <= '0;
        else if (we && (wr_idx == IDX_W'(i)) && be[l])
          mem[i][l*8 +: 8] <= wdata[l*8 +: 8];
      end
    end
  end

  assign rdata = mem[rd_idx];
endmodule

// File: rtl/async_bus_slave.sv
module async_bus_slave
  import abs_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int IO_W     = 13,
  parameter int WIN_BASE = 'h1F00,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_ctl,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_msync,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_ssync
);
  localparam int NB     = DATA_W / 8;
  localparam int LANE_W = (NB > 1) ? $clog2(NB) : 1;
  localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int IN_W   = ADDR_W + 2 + DATA_W;

  logic [IN_W-1:0]   fields_s;
  logic              msync_s;
  slv_state_e        st;
  logic [ADDR_W-1:0] cap_addr;
  xfer_e             cap_ctl;
  logic [DATA_W-1:0] cap_din;
  logic              lock_v;
  logic [IDX_W-1:0]  lock_idx;
  logic [DATA_W-1:0] rd_q;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rf_rdata;
  logic [NB-1:0]     be;
  logic              is_write, is_read, lock_ok, accept, wr_en;

  abs_sync #(.W(IN_W)) u_sync_fields (
    .clk(clk), .rst_n(rst_n),
    .d({bus_addr, bus_ctl, bus_din}), .q(fields_s)
  );

  abs_sync #(.W(1)) u_sync_msync (
    .clk(clk), .rst_n(rst_n), .d(bus_msync), .q(msync_s)
  );

  abs_decode #(
    .ADDR_W(ADDR_W), .IO_W(IO_W), .WIN_BASE(WIN_BASE),
    .NUM_REGS(NUM_REGS), .LANE_W(LANE_W), .IDX_W(IDX_W)
  ) u_decode (
    .addr(cap_addr), .hit(hit), .idx(idx)
  );

  always_comb begin
    is_write = (cap_ctl == XF_WR_WORD) || (cap_ctl == XF_WR_BYTE);
    is_read  = !is_write;
    lock_ok  = !lock_v || (idx == lock_idx) || (cap_ctl == XF_READ);
    accept   = hit && lock_ok;
    wr_en    = (st == ST_SETTLE) && accept && is_write;
    if (cap_ctl == XF_WR_BYTE) begin
      be = '0;
      be[cap_addr[LANE_W-1:0]] = 1'b1;
    end else begin
      be = '1;
    end
  end

  abs_regfile #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en), .wr_idx(idx), .be(be), .wdata(cap_din),
    .rd_idx(idx), .rdata(rf_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cap_addr <= '0;
      cap_ctl  <= XF_READ;
      cap_din  <= '0;
      lock_v   <= 1'b0;
      lock_idx <= '0;
      rd_q     <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (msync_s) begin
            cap_addr <= fields_s[IN_W-1 -: ADDR_W];
            cap_ctl  <= xfer_e'(fields_s[DATA_W +: 2]);
            cap_din  <= fields_s[DATA_W-1:0];
            st       <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (accept) begin
            st   <= ST_HOLD;
            rd_q <= is_read ? rf_rdata : '0;
            if (cap_ctl == XF_READ_PAUSE) begin
              lock_v   <= 1'b1;
              lock_idx <= idx;
            end else if (is_write && lock_v && (idx == lock_idx)) begin
              lock_v <= 1'b0;
            end
          end else begin
            st <= ST_REFUSE;
          end
        end
        ST_HOLD: begin
          if (!msync_s) begin
            st   <= ST_IDLE;
            rd_q <= '0;
          end
        end
        ST_REFUSE: begin
          if (!msync_s) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign bus_ssync = (st == ST_HOLD);
  assign bus_dout  = rd_q;

  // R7: answer only rises while the synchronised master strobe is up
  a_r7_ack_needs_msync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ssync) |-> msync_s);

  // R7: answer held as long as the master strobe is held
  a_r7_hold_while_msync: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ssync && msync_s) |=> bus_ssync);

  // R4: no read data outside an answer
  a_r4_dout_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ssync |-> (bus_dout == '0));

  // R2: an address outside the window is never answered
  a_r2_unmapped_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_SETTLE) && !hit) |=> !bus_ssync);

  // R9: a lock holder's register is the only one that may be modified
  a_r9_locked_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_SETTLE) && lock_v && (cap_ctl != XF_READ) && (idx != lock_idx))
      |=> !bus_ssync);

  // R8: a write to the locked register releases the lock
  a_r8_lock_release: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_SETTLE) && hit && lock_v && is_write && (idx == lock_idx))
      |=> !lock_v);
endmodule

// File: tb/sim_async_bus_slave.sv
module sim_async_bus_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] bus_addr = '0;
  logic [1:0]  bus_ctl = '0;
  logic [15:0] bus_din = '0;
  logic        bus_msync = 1'b0;
  logic [15:0] bus_dout;
  logic        bus_ssync;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  bit run = 0;
  bit prev_ssync = 0;

  logic [15:0] mdl [8];
  bit lk_v = 0;
  int lk_i = 0;

  always #4 clk = ~clk;

  async_bus_slave u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_ctl(bus_ctl),
    .bus_din(bus_din), .bus_msync(bus_msync), .bus_dout(bus_dout),
    .bus_ssync(bus_ssync)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock ordering and idle-data checks
  always @(negedge clk) begin
    if (run) begin
      chk(!( !bus_msync && !prev_ssync && bus_ssync ), "R7 ssync rose without msync",
          32'(bus_ssync), 32'h0);
      if (!bus_ssync) chk(bus_dout == 16'h0, "R4 dout idle", 32'(bus_dout), 32'h0);
    end
    prev_ssync = bus_ssync;
  end

  task automatic xfer(input logic [17:0] a, input logic [1:0] c,
                      input logic [15:0] d, input string tag);
    bit mapped;
    int k;
    bit exp_ack;
    logic [15:0] exp_d;
    bit got;
    int n;
    mapped = (a[17:13] == 5'h1F) && (a[12:0] >= 13'h1F00) && (a[12:0] < 13'h1F10);
    k = (int'(a[12:0]) - 'h1F00) >>> 1;
    if (!mapped) exp_ack = 0;
    else if (c == 2'b00) exp_ack = 1;
    else exp_ack = !lk_v || (lk_i == k);
    exp_d = (exp_ack && c < 2) ? mdl[k] : 16'h0;

    @(posedge clk); #1;
    bus_addr = a; bus_ctl = c; bus_din = d;
    @(posedge clk); #1;
    bus_msync = 1'b1;
    got = 0;
    n = 0;
    while (n < 12) begin
      @(negedge clk);
      n++;
      if (bus_ssync) begin got = 1; break; end
    end
    chk(got == exp_ack, {tag, " ack"}, 32'(got), 32'(exp_ack));
    if (got) begin
      chk(n <= 8, {tag, " R7 ack latency"}, n, 8);
      chk(bus_dout == exp_d, {tag, " data"}, 32'(bus_dout), 32'(exp_d));
      repeat (3) begin
        @(negedge clk);
        chk(bus_ssync, {tag, " R7 ssync held"}, 32'(bus_ssync), 32'h1);
      end
    end
    @(posedge clk); #1;
    bus_msync = 1'b0;
    n = 0;
    while (n < 12) begin
      @(negedge clk);
      n++;
      if (!bus_ssync) break;
    end
    chk(!bus_ssync && n <= 8, {tag, " R7 ssync release"}, 32'(bus_ssync), 32'h0);
    repeat (4) @(posedge clk);

    if (exp_ack) begin
      if (c == 2'b01) begin lk_v = 1; lk_i = k; end
      else if (c[1]) begin
        if (lk_v && lk_i == k) lk_v = 0;
        if (c == 2'b10) mdl[k] = d;
        else if (a[0]) mdl[k][15:8] = d[15:8];
        else mdl[k][7:0] = d[7:0];
      end
    end
  endtask

  function automatic logic [17:0] ra(input int k);
    return 18'h3FF00 + 18'(2 * k);
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 16'h0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(bus_ssync == 1'b0, "R1 ssync reset", 32'(bus_ssync), 32'h0);
    chk(bus_dout == 16'h0, "R1 dout reset", 32'(bus_dout), 32'h0);
    #1 rst_n = 1'b1;
    run = 1;

    for (int i = 0; i < 8; i++) xfer(ra(i), 2'b00, 16'h0, "R1 R3 reset read");
    for (int i = 0; i < 8; i++) xfer(ra(i), 2'b10, 16'hA5C0 ^ 16'(i * 16'h1111), "R5 word write");
    for (int i = 0; i < 8; i++) xfer(ra(i), 2'b00, 16'h0, "R5 readback");

    xfer(ra(2), 2'b11, 16'hFF3C, "R6 low lane");
    xfer(ra(2), 2'b00, 16'h0, "R6 low lane read");
    xfer(ra(3) + 18'd1, 2'b11, 16'h7EFF, "R6 high lane");
    xfer(ra(3), 2'b00, 16'h0, "R6 high lane read");

    xfer(18'h00100, 2'b00, 16'h0, "R2 low memory");
    xfer(18'h3E000, 2'b10, 16'h1234, "R2 page below window");
    xfer(18'h3FF10, 2'b00, 16'h0, "R2 past window");
    xfer(18'h3FEFE, 2'b10, 16'h4321, "R2 before window");
    xfer(18'h1FF00, 2'b00, 16'h0, "R2 outside page");
    xfer(ra(0), 2'b00, 16'h0, "R10 recovery read");
    xfer(18'h3FF0F, 2'b11, 16'h9900, "R2 R6 last byte");
    xfer(ra(7), 2'b00, 16'h0, "R2 last word read");

    xfer(ra(4), 2'b01, 16'h0, "R3 R8 paused read");
    xfer(ra(5), 2'b10, 16'hDEAD, "R9 write other refused");
    xfer(ra(6), 2'b01, 16'h0, "R9 pause other refused");
    xfer(ra(5), 2'b11, 16'h00EE, "R9 byte other refused");
    xfer(ra(5), 2'b00, 16'h0, "R9 read other served");
    xfer(ra(4) + 18'd1, 2'b11, 16'h5A00, "R8 R6 completing byte write");
    xfer(ra(4), 2'b00, 16'h0, "R8 rmw result");
    xfer(ra(5), 2'b10, 16'hBEEF, "R8 lock released");
    xfer(ra(1), 2'b01, 16'h0, "R8 paused read two");
    xfer(ra(1), 2'b10, 16'h0F0F, "R8 completing word write");
    xfer(ra(6), 2'b10, 16'hC001, "R8 R10 free again");

    for (int i = 0; i < 8; i++) xfer(ra(i), 2'b00, 16'h0, "R5 R6 final contents");

    done = 1;
    run = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule